// File: doc/BRIEF.md
# Leaky Bucket Reference Activity Monitor

This block judges whether one reference clock input is usable. Once per monitoring tick, an enable that nominally arrives every eighth of a second, it receives a flag saying whether any edge of the reference was seen during the interval just ended. It feeds that flag into a leaky-bucket accumulator and drives an inactivity alarm with hysteresis.

Each quiet tick adds one unit to the bucket. The bucket never grows past the programmed size. Active ticks let the bucket drain, but slowly: one unit leaves for every 2^rate active ticks, counted by a small prescaler. The alarm rises once the fill reaches the upper threshold. It falls only when the fill has drained to the lower threshold. Between the two thresholds it keeps its last state.

With the typical settings, the timing is as follows:

- Upper threshold 6: an input that was fully active raises the alarm after 6 quiet ticks, which is 0.75 s.
- Size 8, lower threshold 4, rate 1: a full bucket clears the alarm after 2 × (8 − 4) = 8 active ticks, which is 1.0 s.
- An input that fails only now and then takes longer to raise the alarm, because its active ticks keep draining the bucket.

Top module: `bucket_watch`

## Requirements
- R1: While reset is asserted, the fill level goes to 0, the drain prescaler goes to 0 and the alarm goes low.
- R2: A tick with `active` low adds 1 to the fill level. The fill never exceeds `cfg_size`; a fill above `cfg_size` is clamped to `cfg_size` on such a tick.
- R3: A tick with `active` high advances the drain prescaler. On the 2^`cfg_rate`-th such tick, the fill drops by 1 and the prescaler restarts at 0. Quiet ticks leave the prescaler unchanged.
- R4: Draining never takes the fill below 0.
- R5: On a tick that leaves the fill at or above `cfg_hi`, the alarm is high after that clock edge.
- R6: On a tick that leaves the fill at or below `cfg_lo` and below `cfg_hi`, the alarm is low after that clock edge. With size 8, lower threshold 4 and rate 1, this takes 8 active ticks from a full bucket.
- R7: On a tick that leaves the fill strictly between `cfg_lo` and `cfg_hi`, the alarm keeps its previous value.
- R8: In cycles where `tick` is low, `level` and `alarm` do not change, whatever `active` does.
- R9: `cfg_rate` is a 2-bit field. Rate 0 drains one unit on every active tick, and rate 3 drains one unit on every 8th active tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle monitoring interval strobe |
| active | input | 1 | Reference edge seen in the interval, sampled with `tick` |
| cfg_size | input | 8 | Bucket capacity |
| cfg_hi | input | 8 | Fill at which the alarm sets |
| cfg_lo | input | 8 | Fill at which the alarm clears |
| cfg_rate | input | 2 | Drain prescale exponent: one unit leaves per 2^rate active ticks |
| level | output | 8 | Current bucket fill |
| alarm | output | 1 | Inactivity alarm, high means the input is invalid |

## Verification
The first pattern is a long run of quiet ticks. It shows whether the alarm rises on exactly the tick that reaches the upper threshold, and whether the fill stops at the bucket size.

A long run of active ticks comes next. It separates a correct prescaled drain from a drain on every tick. It also shows that the alarm stays high through the hysteresis band, falls exactly at the lower threshold, and that the fill stops at zero.

Alternating quiet and active ticks test whether quiet ticks disturb the prescaler. Runs at rates 0 and 3, and with a small bucket, test how the drain period and the saturation point follow the settings. Toggling `active` with no tick tests that nothing moves between ticks.

// File: rtl/bucket_watch.sv
module bucket_watch #(
  parameter int CW     = 8,
  parameter int RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              active,
  input  logic [CW-1:0]     cfg_size,
  input  logic [CW-1:0]     cfg_hi,
  input  logic [CW-1:0]     cfg_lo,
  input  logic [RATE_W-1:0] cfg_rate,
  output logic [CW-1:0]     level,
  output logic              alarm
);
  localparam int PRE_W = (1 << RATE_W) - 1;

  logic [CW-1:0]    lvl_q, lvl_d;
  logic [PRE_W-1:0] pre_q, pre_d, pre_lim;
  logic             alm_q, alm_d;
  logic             leak;

  assign pre_lim = {PRE_W{1'b1}} >> (RATE_W'(PRE_W) - cfg_rate);
  assign leak    = active && (pre_q == pre_lim);

  always_comb begin
    lvl_d = lvl_q;
    pre_d = pre_q;
    alm_d = alm_q;
    if (tick) begin
      if (!active) begin
        if (lvl_q < cfg_size)      lvl_d = lvl_q + CW'(1);
        else                       lvl_d = cfg_size;
      end else begin
        pre_d = leak ? '0 : pre_q + PRE_W'(1);
        if (leak && lvl_q != '0)   lvl_d = lvl_q - CW'(1);
      end
      if (lvl_d >= cfg_hi)         alm_d = 1'b1;
      else if (lvl_d <= cfg_lo)    alm_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= '0;
      pre_q <= '0;
      alm_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      pre_q <= pre_d;
      alm_q <= alm_d;
    end
  end

  assign level = lvl_q;
  assign alarm = alm_q;
endmodule

// File: rtl/bucket_watch_chk.sv
module bucket_watch_chk #(
  parameter int CW     = 8,
  parameter int RATE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              active,
  input logic [CW-1:0]     cfg_size,
  input logic [CW-1:0]     cfg_hi,
  input logic [CW-1:0]     cfg_lo,
  input logic [RATE_W-1:0] cfg_rate,
  input logic [CW-1:0]     level,
  input logic              alarm
);
  a_r1_reset_empty: assert property (@(posedge clk)
    !rst_n |=> (level == '0 && !alarm));

  a_r2_quiet_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !active && level < cfg_size && $stable(cfg_size)) |=> level == $past(level) + CW'(1));

  a_r3_active_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && active) |=> level <= $past(level));

  a_r5_raise_at_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (level >= cfg_hi && $stable(cfg_hi)) |-> alarm);

  a_r6_clear_at_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (level <= cfg_lo && level < cfg_hi && $stable(cfg_lo) && $stable(cfg_hi)) |-> !alarm);

  a_r8_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && $past(rst_n)) |=> ($stable(level) && $stable(alarm)));
endmodule

bind bucket_watch bucket_watch_chk #(.CW(CW), .RATE_W(RATE_W)) u_chk (.*);

// File: tb/sim_bucket_watch.sv
module sim_bucket_watch;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       active = 1'b0;
  logic [7:0] cfg_size = 8'd8, cfg_hi = 8'd6, cfg_lo = 8'd4;
  logic [1:0] cfg_rate = 2'd1;
  logic [7:0] level;
  logic       alarm;

  int compared = 0, mismatched = 0, cycles = 0;
  int    q_lvl[$];
  bit    q_alm[$];
  string q_tag[$];
  int m_lvl, m_pre, m_alm;
  logic t_seen = 1'b0;

  always #4 clk = ~clk;

  bucket_watch u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .active(active),
    .cfg_size(cfg_size), .cfg_hi(cfg_hi), .cfg_lo(cfg_lo), .cfg_rate(cfg_rate),
    .level(level), .alarm(alarm));

  task automatic check(string tag, int got_l, int exp_l, int got_a, int exp_a);
    compared++;
    if (got_l != exp_l || got_a != exp_a) begin
      mismatched++;
      $display("FAIL %s: level=%0d alarm=%0d expected level=%0d alarm=%0d",
               tag, got_l, got_a, exp_l, exp_a);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; tick = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R1 reset", level, 0, alarm, 0);
    rst_n = 1'b1;
    m_lvl = 0; m_pre = 0; m_alm = 0;
  endtask

  // driver: one tick, expected outcome from the requirements
  task automatic do_tick(bit a, string tag);
    int lim;
    lim = (1 << cfg_rate) - 1;
    if (!a) begin
      m_lvl = (m_lvl < cfg_size) ? m_lvl + 1 : cfg_size;
    end else if (m_pre == lim) begin
      m_pre = 0;
      if (m_lvl > 0) m_lvl = m_lvl - 1;
    end else m_pre = m_pre + 1;
    if (m_lvl >= cfg_hi) m_alm = 1;
    else if (m_lvl <= cfg_lo) m_alm = 0;
    q_lvl.push_back(m_lvl); q_alm.push_back(m_alm[0]); q_tag.push_back(tag);
    @(negedge clk); tick = 1'b1; active = a;
    @(negedge clk); tick = 1'b0; active = 1'b0;
  endtask

  // monitor
  always @(posedge clk) t_seen <= tick;
  always @(negedge clk) begin
    if (t_seen && q_lvl.size() > 0) begin
      automatic int    el = q_lvl.pop_front();
      automatic bit    ea = q_alm.pop_front();
      automatic string tg = q_tag.pop_front();
      check(tg, level, el, alarm, ea);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      mismatched++;
      $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    do_reset();
    for (int i = 0; i < 5; i++) do_tick(0, "R5 below hi");
    do_tick(0, "R5 reach hi");
    for (int i = 0; i < 4; i++) do_tick(0, "R2 saturate");
    do_tick(1, "R3 prescale hold");
    do_tick(1, "R3 drain");
    for (int i = 0; i < 4; i++) do_tick(1, "R7 hold band");
    do_tick(1, "R6 near lo");
    do_tick(1, "R6 clear at lo");
    for (int i = 0; i < 12; i++) do_tick(1, "R4 floor zero");
    // R8: no tick, active toggles
    for (int i = 0; i < 6; i++) do_tick(0, "R8 prefill");
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); active = i[0];
    end
    @(negedge clk); active = 1'b0;
    check("R8 no tick", level, m_lvl, alarm, m_alm);
    // R3 intermittent input
    do_reset();
    for (int i = 0; i < 10; i++) begin
      do_tick(0, "R3 intermittent quiet");
      do_tick(1, "R3 intermittent active");
    end
    // R9 rate 0 and rate 3
    cfg_rate = 2'd0; do_reset();
    for (int i = 0; i < 8; i++) do_tick(0, "R9 fill r0");
    for (int i = 0; i < 9; i++) do_tick(1, "R9 drain r0");
    cfg_rate = 2'd3; do_reset();
    for (int i = 0; i < 8; i++) do_tick(0, "R9 fill r3");
    for (int i = 0; i < 40; i++) do_tick(1, "R9 drain r3");
    // R2 small bucket
    cfg_size = 8'd3; cfg_hi = 8'd2; cfg_lo = 8'd0; cfg_rate = 2'd1; do_reset();
    for (int i = 0; i < 6; i++) do_tick(0, "R2 small size");
    for (int i = 0; i < 8; i++) do_tick(1, "R6 small drain");
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule